// File: doc/BRIEF.md
# Branch and Skip Decision Unit

This unit makes the program-flow decision for a small 8-bit microcontroller core. Each cycle it may receive one decoded flow opcode with its context: the address of the current instruction, the four arithmetic flags, a raw signed offset field, a file operand, the working operand, a bit index, and a hint that says whether the following instruction occupies two words. One clock later it presents the address of the next instruction to fetch. That address is one of three things: the next sequential word, a relative branch target, or the address past the following instruction when that instruction is skipped.

Relative branches measure their offset in instruction words from the address after the branch. Eight of them depend on a single flag being set or clear. One branch is always taken and has a wider offset field. The skip group decides from data alone: a bit test, an unsigned comparison of F against W, a zero test, or an increment or decrement whose new value is also returned for writeback. No operation here alters the flags, and the unit passes them through unchanged.

Top module: `flow_sel`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid`, `br_taken`, `skip_next`, `next_pc`, `upd_val` and `flags_out` are all zero.
- R2: Opcodes 1 to 8 are conditional branches on the `flags_in` bits {N,OV,Z,C} = bits 3..0. They take the branch when C=1 (1), C=0 (2), Z=1 (3), Z=0 (4), N=1 (5), N=0 (6), OV=1 (7) or OV=0 (8). A taken branch gives `next_pc = pc + 2 + 2*n`, where n is `ofs_in[6:0]` sign-extended, and raises `br_taken`.
- R3: A conditional branch whose condition fails gives `next_pc = pc + 2`, with `br_taken` and `skip_next` low.
- R4: Opcode 9 is always taken and uses all ten bits of `ofs_in`, sign-extended, as n.
- R5: A negative n moves the target backward. All address arithmetic wraps modulo 2^PC_W.
- R6: Opcode 10 skips when bit `bit_sel` of `f_in` is 0, and opcode 11 skips when that bit is 1.
- R7: Opcodes 12, 13 and 14 skip when F = W, F > W and F < W respectively, with both operands compared as unsigned.
- R8: Opcode 15 skips when `f_in` is zero.
- R9: Opcodes 16 and 17 give `upd_val = f_in - 1`, and opcodes 18 and 19 give `upd_val = f_in + 1`, both modulo 256. Opcodes 16 and 18 skip when the new value is zero. Opcodes 17 and 19 skip when it is non-zero. For every other opcode, `upd_val = f_in`.
- R10: A skip gives `next_pc = pc + 4`, or `pc + 6` when `skip_two_word` is high, and raises `skip_next`.
- R11: For every accepted operation, `flags_out` equals the `flags_in` that came with it.
- R12: Opcode 0 and the undefined codes 20 to 31 give `next_pc = pc + 2`, with no branch and no skip.
- R13: The results appear exactly one cycle after `in_valid`. A cycle with `in_valid` low gives `out_valid`, `br_taken` and `skip_next` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is present this cycle |
| op_code | input | 5 | Flow opcode (encoding in R2 to R12) |
| pc_in | input | PC_W | Byte address of the current instruction |
| flags_in | input | 4 | {N,OV,Z,C} |
| ofs_in | input | LONG_OFS_W | Raw signed word-offset field |
| f_in | input | DATA_W | File operand |
| w_in | input | DATA_W | Working operand |
| bit_sel | input | clog2(DATA_W) | Bit index for bit tests |
| skip_two_word | input | 1 | The following instruction is two words long |
| out_valid | output | 1 | Results valid |
| next_pc | output | PC_W | Next fetch address |
| br_taken | output | 1 | A relative branch was taken |
| skip_next | output | 1 | The following instruction is skipped |
| upd_val | output | DATA_W | Updated value for writeback |
| flags_out | output | 4 | Flags, unchanged |

## Verification
The bench builds the unit with its default parameters: a 21-bit PC, 8-bit data, a 7-bit conditional offset and a 10-bit unconditional offset. These widths let directed cases reach both ends of each offset range, -64/+63 and -512/+511, and place the PC at zero and at the top of the address space, so wrap-around occurs in both directions. The 8-bit data width brings the unsigned compare boundary (0x80 against 0x7F) and the roll-over of increment at 0xFF and decrement at 0x00 within reach. Random operations, including undefined opcodes and idle cycles, are then compared every clock against a behavioural model.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int OP_W = 5;
  localparam int FLAG_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_SEQ   = 5'd0,
    OP_CSET  = 5'd1,
    OP_CCLR  = 5'd2,
    OP_ZSET  = 5'd3,
    OP_ZCLR  = 5'd4,
    OP_NSET  = 5'd5,
    OP_NCLR  = 5'd6,
    OP_VSET  = 5'd7,
    OP_VCLR  = 5'd8,
    OP_ALWAYS= 5'd9,
    OP_BIT0  = 5'd10,
    OP_BIT1  = 5'd11,
    OP_FEQ   = 5'd12,
    OP_FGT   = 5'd13,
    OP_FLT   = 5'd14,
    OP_FZERO = 5'd15,
    OP_DECZ  = 5'd16,
    OP_DECNZ = 5'd17,
    OP_INCZ  = 5'd18,
    OP_INCNZ = 5'd19
  } flow_op_e;

  // flag bit positions inside the flag vector
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_V = 2;
  localparam int FL_N = 3;
endpackage

// File: rtl/flow_branch_eval.sv
module flow_branch_eval
  import flow_pkg::*;
#(
  parameter int PC_W       = 21,
  parameter int COND_OFS_W = 7,
  parameter int LONG_OFS_W = 10
) (
  input  flow_op_e              op,
  input  logic [FLAG_W-1:0]     flags,
  input  logic [LONG_OFS_W-1:0] ofs,
  input  logic [PC_W-1:0]       pc,
  output logic                  take,
  output logic [PC_W-1:0]       target
);
  localparam int EXT_C = PC_W - COND_OFS_W;
  localparam int EXT_L = PC_W - LONG_OFS_W;
  localparam logic [PC_W-1:0] WORD = PC_W'(2);

  logic [PC_W-1:0] ofs_short, ofs_long, ofs_sel;
  logic            is_long;

  assign ofs_short = {{EXT_C{ofs[COND_OFS_W-1]}}, ofs[COND_OFS_W-1:0]};
  assign ofs_long  = {{EXT_L{ofs[LONG_OFS_W-1]}}, ofs};

  always_comb begin
    is_long = 1'b0;
    unique case (op)
      OP_CSET:   take =  flags[FL_C];
      OP_CCLR:   take = !flags[FL_C];
      OP_ZSET:   take =  flags[FL_Z];
      OP_ZCLR:   take = !flags[FL_Z];
      OP_NSET:   take =  flags[FL_N];
      OP_NCLR:   take = !flags[FL_N];
      OP_VSET:   take =  flags[FL_V];
      OP_VCLR:   take = !flags[FL_V];
      OP_ALWAYS: begin take = 1'b1; is_long = 1'b1; end
      default:   take = 1'b0;
    endcase
  end

  assign ofs_sel = is_long ? ofs_long : ofs_short;
  assign target  = pc + WORD + {ofs_sel[PC_W-2:0], 1'b0};
endmodule

// File: rtl/flow_skip_eval.sv
module flow_skip_eval
  import flow_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  flow_op_e                    op,
  input  logic [DATA_W-1:0]           f,
  input  logic [DATA_W-1:0]           w,
  input  logic [$clog2(DATA_W)-1:0]   bsel,
  output logic                        skip,
  output logic [DATA_W-1:0]           upd
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] dec_v, inc_v;
  logic              tbit;

  assign dec_v = f - ONE;
  assign inc_v = f + ONE;
  assign tbit  = f[bsel];

  always_comb begin
    upd = f;
    unique case (op)
      OP_BIT0:  skip = !tbit;
      OP_BIT1:  skip =  tbit;
      OP_FEQ:   skip = (f == w);
      OP_FGT:   skip = (f > w);
      OP_FLT:   skip = (f < w);
      OP_FZERO: skip = (f == '0);
      OP_DECZ:  begin upd = dec_v; skip = (dec_v == '0); end
      OP_DECNZ: begin upd = dec_v; skip = (dec_v != '0); end
      OP_INCZ:  begin upd = inc_v; skip = (inc_v == '0); end
      OP_INCNZ: begin upd = inc_v; skip = (inc_v != '0); end
      default:  skip = 1'b0;
    endcase
  end
endmodule

// File: rtl/flow_sel.sv
module flow_sel
  import flow_pkg::*;
#(
  parameter int PC_W       = 21,
  parameter int DATA_W     = 8,
  parameter int COND_OFS_W = 7,
  parameter int LONG_OFS_W = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [4:0]                op_code,
  input  logic [PC_W-1:0]           pc_in,
  input  logic [3:0]                flags_in,
  input  logic [LONG_OFS_W-1:0]     ofs_in,
  input  logic [DATA_W-1:0]         f_in,
  input  logic [DATA_W-1:0]         w_in,
  input  logic [$clog2(DATA_W)-1:0] bit_sel,
  input  logic                      skip_two_word,
  output logic                      out_valid,
  output logic [PC_W-1:0]           next_pc,
  output logic                      br_taken,
  output logic                      skip_next,
  output logic [DATA_W-1:0]         upd_val,
  output logic [3:0]                flags_out
);
  localparam logic [PC_W-1:0] STEP1 = PC_W'(2);
  localparam logic [PC_W-1:0] STEP2 = PC_W'(4);
  localparam logic [PC_W-1:0] STEP3 = PC_W'(6);

  flow_op_e          op;
  logic              take_c, skip_c;
  logic [PC_W-1:0]   target_c, pc_c;
  logic [DATA_W-1:0] upd_c;

  assign op = flow_op_e'(op_code);

  flow_branch_eval #(
    .PC_W(PC_W), .COND_OFS_W(COND_OFS_W), .LONG_OFS_W(LONG_OFS_W)
  ) u_br (
    .op(op), .flags(flags_in), .ofs(ofs_in), .pc(pc_in),
    .take(take_c), .target(target_c)
  );

  flow_skip_eval #(.DATA_W(DATA_W)) u_sk (
    .op(op), .f(f_in), .w(w_in), .bsel(bit_sel),
    .skip(skip_c), .upd(upd_c)
  );

  always_comb begin
    if (take_c)      pc_c = target_c;
    else if (skip_c) pc_c = pc_in + (skip_two_word ? STEP3 : STEP2);
    else             pc_c = pc_in + STEP1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      br_taken  <= 1'b0;
      skip_next <= 1'b0;
      next_pc   <= '0;
      upd_val   <= '0;
      flags_out <= '0;
    end else begin
      out_valid <= in_valid;
      br_taken  <= in_valid && take_c;
      skip_next <= in_valid && skip_c;
      if (in_valid) begin
        next_pc   <= pc_c;
        upd_val   <= upd_c;
        flags_out <= flags_in;
      end
    end
  end

  // R2 R10: a branch and a skip never both apply
  p_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(br_taken && skip_next));

  // R3 R12: neither taken nor skipped means one word ahead
  p_seq_r12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !br_taken && !skip_next) |-> (next_pc == $past(pc_in) + STEP1));

  // R10: skip distance follows the two-word hint
  p_skipdist_r10: assert property (@(posedge clk) disable iff (rst)
    skip_next |-> (next_pc == $past(pc_in) + ($past(skip_two_word) ? STEP3 : STEP2)));

  // R11: flags pass unchanged
  p_flags_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (flags_out == $past(flags_in)));

  // R13: idle input gives idle output one cycle later
  p_idle_r13: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !br_taken && !skip_next));

  // R13: valid input is reported one cycle later
  p_lat_r13: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
endmodule

// File: tb/sim_flow_sel.sv
`timescale 1ns/1ps
module sim_flow_sel;
  localparam int PC_W = 21;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [PC_W-1:0] pc_in = '0;
  logic [3:0] flags_in = '0;
  logic [9:0] ofs_in = '0;
  logic [DATA_W-1:0] f_in = '0, w_in = '0;
  logic [2:0] bit_sel = '0;
  logic skip_two_word = 1'b0;
  logic out_valid, br_taken, skip_next;
  logic [PC_W-1:0] next_pc;
  logic [DATA_W-1:0] upd_val;
  logic [3:0] flags_out;

  int errors = 0, checks = 0;
  bit done = 0;

  // expected values of the operation driven last
  bit have_exp = 0;
  bit e_v, e_take, e_skip;
  logic [PC_W-1:0] e_pc;
  logic [DATA_W-1:0] e_upd;
  logic [3:0] e_fl;
  string e_tag;

  always #2.5 clk = ~clk;

  flow_sel u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .pc_in(pc_in), .flags_in(flags_in), .ofs_in(ofs_in), .f_in(f_in),
    .w_in(w_in), .bit_sel(bit_sel), .skip_two_word(skip_two_word),
    .out_valid(out_valid), .next_pc(next_pc), .br_taken(br_taken),
    .skip_next(skip_next), .upd_val(upd_val), .flags_out(flags_out)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    if (!have_exp) return;
    chk("R13", "out_valid", 32'(out_valid), 32'(e_v));
    chk(e_tag, "br_taken", 32'(br_taken), 32'(e_take));
    chk(e_tag, "skip_next", 32'(skip_next), 32'(e_skip));
    if (e_v) begin
      chk(e_tag, "next_pc", 32'(next_pc), 32'(e_pc));
      chk("R9", "upd_val", 32'(upd_val), 32'(e_upd));
      chk("R11", "flags_out", 32'(flags_out), 32'(e_fl));
    end
  endtask

  task automatic model(bit v, int op, logic [PC_W-1:0] pc, logic [3:0] fl,
                       logic [9:0] ofs, logic [7:0] f, logic [7:0] w,
                       int b, bit two);
    int n;
    bit t, s;
    logic [7:0] u;
    t = 0; s = 0; u = f;
    n = int'(ofs[6:0]);
    if (n >= 64) n -= 128;
    case (op)
      1: t = fl[0];   2: t = !fl[0];
      3: t = fl[1];   4: t = !fl[1];
      5: t = fl[3];   6: t = !fl[3];
      7: t = fl[2];   8: t = !fl[2];
      9: begin t = 1; n = int'(ofs); if (n >= 512) n -= 1024; end
      10: s = (f[b] == 1'b0);
      11: s = (f[b] == 1'b1);
      12: s = (f == w);
      13: s = (int'(f) > int'(w));
      14: s = (int'(f) < int'(w));
      15: s = (f == 8'd0);
      16: begin u = f - 8'd1; s = (u == 0); end
      17: begin u = f - 8'd1; s = (u != 0); end
      18: begin u = f + 8'd1; s = (u == 0); end
      19: begin u = f + 8'd1; s = (u != 0); end
      default: ;
    endcase
    e_v = v; e_take = v && t; e_skip = v && s;
    if (v) begin
      if (t) e_pc = PC_W'(int'(pc) + 2 + 2 * n);
      else if (s) e_pc = pc + PC_W'(two ? 6 : 4);
      else e_pc = pc + PC_W'(2);
      e_upd = u; e_fl = fl;
    end
    if (op >= 1 && op <= 8) e_tag = !t ? "R3" : (n < 0 ? "R5" : "R2");
    else if (op == 9) e_tag = (n < 0) ? "R5" : "R4";
    else if (op == 10 || op == 11) e_tag = "R6";
    else if (op >= 12 && op <= 14) e_tag = "R7";
    else if (op == 15) e_tag = "R8";
    else if (op >= 16 && op <= 19) e_tag = "R9";
    else e_tag = "R12";
    if (s && two) e_tag = "R10";
    if (!v) e_tag = "R13";
    have_exp = 1;
  endtask

  task automatic step(bit v, int op, logic [PC_W-1:0] pc, logic [3:0] fl,
                      logic [9:0] ofs, logic [7:0] f, logic [7:0] w,
                      int b, bit two);
    @(negedge clk);
    compare();
    in_valid = v; op_code = 5'(op); pc_in = pc; flags_in = fl;
    ofs_in = ofs; f_in = f; w_in = w; bit_sel = 3'(b); skip_two_word = two;
    model(v, op, pc, fl, ofs, f, w, b, two);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1; op_code = 5'd9; pc_in = 21'h100;
    repeat (3) @(negedge clk);
    // R1: reset state even with a valid input present
    chk("R1", "out_valid", 32'(out_valid), 0);
    chk("R1", "next_pc", 32'(next_pc), 0);
    chk("R1", "br_taken", 32'(br_taken), 0);
    chk("R1", "skip_next", 32'(skip_next), 0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "upd_val", 32'(upd_val), 0);
    chk("R1", "flags_out", 32'(flags_out), 0);
    chk("R1", "out_valid after release", 32'(out_valid), 0);

    // R2/R3: every conditional branch with its flag set and clear
    for (int op = 1; op <= 8; op++) begin
      step(1, op, 21'h1000, 4'hF, 10'd5, 0, 0, 0, 0);
      step(1, op, 21'h1000, 4'h0, 10'd5, 0, 0, 0, 0);
    end
    // R5: conditional offset extremes, wrap at both ends
    step(1, 1, 21'h0, 4'h1, 10'h040, 0, 0, 0, 0);       // -64 from 0
    step(1, 1, 21'h1FFFFE, 4'h1, 10'h03F, 0, 0, 0, 0);  // +63 at top
    step(1, 1, 21'h200, 4'h1, 10'h3C0, 0, 0, 0, 0);     // upper bits ignored
    // R4/R5: unconditional extremes
    step(1, 9, 21'h800, 4'h0, 10'h1FF, 0, 0, 0, 0);
    step(1, 9, 21'h800, 4'h0, 10'h200, 0, 0, 0, 0);
    step(1, 9, 21'h10, 4'h0, 10'h200, 0, 0, 0, 0);
    // R6: bit tests
    step(1, 10, 21'h40, 4'h0, 0, 8'h7F, 0, 7, 0);
    step(1, 11, 21'h40, 4'h0, 0, 8'h7F, 0, 7, 0);
    step(1, 11, 21'h40, 4'h0, 0, 8'h01, 0, 0, 1);
    // R7: unsigned compare boundary
    step(1, 13, 21'h50, 4'h0, 0, 8'h80, 8'h7F, 0, 0);
    step(1, 14, 21'h50, 4'h0, 0, 8'h80, 8'h7F, 0, 0);
    step(1, 12, 21'h50, 4'h0, 0, 8'hA5, 8'hA5, 0, 1);
    step(1, 13, 21'h50, 4'h0, 0, 8'hA5, 8'hA5, 0, 0);
    // R8
    step(1, 15, 21'h60, 4'h0, 0, 8'h00, 0, 0, 0);
    step(1, 15, 21'h60, 4'h0, 0, 8'h01, 0, 0, 0);
    // R9: roll-over cases
    step(1, 16, 21'h70, 4'h0, 0, 8'h01, 0, 0, 0);
    step(1, 16, 21'h70, 4'h0, 0, 8'h00, 0, 0, 0);
    step(1, 17, 21'h70, 4'h0, 0, 8'h01, 0, 0, 0);
    step(1, 18, 21'h70, 4'h0, 0, 8'hFF, 0, 0, 1);
    step(1, 19, 21'h70, 4'h0, 0, 8'hFF, 0, 0, 0);
    step(1, 19, 21'h1FFFFC, 4'h0, 0, 8'h10, 0, 0, 1);   // R10 wrap
    // R12/R13: sequential, undefined codes, idle
    step(1, 0, 21'h1FFFFE, 4'hA, 10'h3FF, 8'hFF, 8'h00, 0, 1);
    step(1, 25, 21'h300, 4'h5, 10'h001, 8'h00, 8'h00, 0, 1);
    step(0, 9, 21'h300, 4'h5, 10'h001, 0, 0, 0, 0);
    step(0, 18, 21'h300, 4'h5, 10'h001, 8'hFF, 0, 0, 0);

    for (int i = 0; i < 400; i++) begin
      step(($urandom % 8) != 0, int'($urandom % 32), PC_W'($urandom),
           4'($urandom), 10'($urandom), 8'($urandom),
           (i % 5 == 0) ? 8'h33 : 8'($urandom), int'($urandom % 8),
           1'($urandom));
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule